// File: doc/BRIEF.md
# Parallel-Port Image Load Controller

This block lets a host push a memory image into an emulation RAM through a printer-style parallel port, one byte at a time. The host drives an active-low strobe with a data byte, and the block handshakes through BUSY and ACK. Each byte is written into the RAM at an address that counts up from zero. While a load runs, the block holds the target system in reset and owns the RAM write port. When the host goes quiet, control of the memory returns to the target and the target restarts.

The strobe is asynchronous. It is synchronized inside the block and both of its edges are used. The falling edge latches the byte and the current load address, and it raises BUSY. The rising edge starts a write pulse of fixed length, and ACK is asserted for the same cycles. When that pulse ends, BUSY drops and the address advances. An idle timer restarts with every byte. When it expires, the session closes, the target reset is released and the address counter goes back to zero.

Top module: `pport_loader`

## Requirements
- R1: After reset, loadMode is 0, busy is 0, ramWe and ack are 0, activity is 0 and targetResetN is 1.
- R2: A high-to-low transition of strobeN makes loadMode, busy and activity 1 and targetResetN 0 within four clock cycles. The byte on dataIn at that moment is captured.
- R3: A low-to-high transition of strobeN that follows a capture drives ramWe and ack high together for exactly PULSE_CYCLES consecutive cycles. During those cycles ramData and ramAddr hold steady at the captured byte and its address.
- R4: When the write pulse ends, busy returns to 0. Each later byte is written at the previous address plus one, and the first byte of a session goes to address 0.
- R5: Once a write pulse has ended, if no new strobe falling edge is seen for TIMEOUT_CYCLES cycles, loadMode and activity return to 0 and targetResetN returns to 1. The next session starts again at address 0.
- R6: During a whole session targetResetN equals the inverse of loadMode, and activity equals loadMode.
- R7: A strobe falling edge that arrives while a write pulse is active is kept, together with its byte. That byte is written at the next address after the pulse ends, even if its rising edge also fell inside the pulse.
- R8: A byte that arrives less than TIMEOUT_CYCLES cycles after the previous write restarts the idle timer. The session stays open and addresses keep counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| strobeN | input | 1 | Asynchronous active-low host strobe |
| dataIn | input | 8 | Host data byte |
| busy | output | 1 | Host handshake: not ready for a new byte |
| ack | output | 1 | Host handshake: byte accepted pulse |
| ramWe | output | 1 | Emulation RAM write enable |
| ramAddr | output | ADDR_W | RAM write address |
| ramData | output | 8 | RAM write data |
| loadMode | output | 1 | 1 while the loader owns the RAM |
| targetResetN | output | 1 | Active-low reset to the target system |
| activity | output | 1 | Drives a load-activity indicator |

## Verification
A stuck or wrong address counter appears at the first write after the fault, as a ramAddr that does not match the running count. A wrong pulse counter appears as a ramWe run of the wrong length, and this is visible at the pulse's falling edge. A pending flag that is lost or stuck shows up as a missing or extra write one pulse later. An idle timer that counts badly keeps loadMode high, or drops it early, within one timeout window of the last write.

// File: rtl/pport_loader_pkg.sv
package pport_loader_pkg;

  typedef enum logic [1:0] {
    ST_EMULATE  = 2'd0,
    ST_WAITRISE = 2'd1,
    ST_PULSE    = 2'd2,
    ST_GAP      = 2'd3
  } loadState_e;

  typedef struct packed {
    logic capNew;    // latch dataIn and current count into holding regs
    logic capPend;   // latch parked byte and current count into holding regs
    logic savePend;  // park dataIn while a write pulse runs
    logic advance;   // step the load counter
    logic clearCnt;  // zero the load counter
  } ctlStrobes_t;

endpackage

// File: rtl/pport_strobe_sync.sv
module pport_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic strobeN,
  output logic fallSeen,
  output logic riseSeen
);
  logic [STAGES-1:0] syncChain;
  logic              lastLvl;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[0] <= 1'b1;
          else       syncChain[0] <= strobeN;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[gi] <= 1'b1;
          else       syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) lastLvl <= 1'b1;
    else       lastLvl <= syncChain[STAGES-1];
  end

  assign fallSeen = lastLvl & ~syncChain[STAGES-1];
  assign riseSeen = ~lastLvl & syncChain[STAGES-1];
endmodule

// File: rtl/pport_load_ctrl.sv
module pport_load_ctrl
  import pport_loader_pkg::*;
#(
  parameter int PULSE_CYCLES   = 8,
  parameter int TIMEOUT_CYCLES = 1000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fallSeen,
  input  logic        riseSeen,
  output ctlStrobes_t ctl,
  output logic        busy,
  output logic        writeActive,
  output logic        sessionActive
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_CYCLES - 1);
  localparam logic [TW-1:0] IDLE_LAST  = TW'(TIMEOUT_CYCLES - 1);

  loadState_e state, stateNext;
  logic [PW-1:0] pulseCnt;
  logic [TW-1:0] idleCnt;
  logic pendFall, pendRise;

  always_comb begin
    stateNext = state;
    ctl = '0;
    unique case (state)
      ST_EMULATE: begin
        if (fallSeen) begin
          ctl.capNew = 1'b1;
          stateNext  = ST_WAITRISE;
        end
      end
      ST_WAITRISE: begin
        if (riseSeen) stateNext = ST_PULSE;
      end
      ST_PULSE: begin
        if (fallSeen) ctl.savePend = 1'b1;
        if (pulseCnt == PULSE_LAST) begin
          ctl.advance = 1'b1;
          stateNext   = ST_GAP;
        end
      end
      ST_GAP: begin
        if (pendFall) begin
          ctl.capPend = 1'b1;
          stateNext   = (pendRise || riseSeen) ? ST_PULSE : ST_WAITRISE;
        end else if (fallSeen) begin
          ctl.capNew = 1'b1;
          stateNext  = ST_WAITRISE;
        end else if (idleCnt == IDLE_LAST) begin
          ctl.clearCnt = 1'b1;
          stateNext    = ST_EMULATE;
        end
      end
      default: stateNext = ST_EMULATE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_EMULATE;
      pulseCnt <= '0;
      idleCnt  <= '0;
      pendFall <= 1'b0;
      pendRise <= 1'b0;
    end else begin
      state    <= stateNext;
      pulseCnt <= (state == ST_PULSE && stateNext == ST_PULSE) ? pulseCnt + 1'b1 : '0;
      idleCnt  <= (state == ST_GAP && stateNext == ST_GAP) ? idleCnt + 1'b1 : '0;
      if (ctl.capPend) begin
        pendFall <= 1'b0;
        pendRise <= 1'b0;
      end else if (state == ST_PULSE) begin
        if (fallSeen) pendFall <= 1'b1;
        if (riseSeen && (pendFall || fallSeen)) pendRise <= 1'b1;
      end
    end
  end

  assign busy          = (state == ST_WAITRISE) || (state == ST_PULSE);
  assign writeActive   = (state == ST_PULSE);
  assign sessionActive = (state != ST_EMULATE);
endmodule

// File: rtl/pport_load_dp.sv
module pport_load_dp
  import pport_loader_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramData
);
  logic [ADDR_W-1:0] loadCnt, addrHold;
  logic [DATA_W-1:0] dataHold, pendData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadCnt  <= '0;
      addrHold <= '0;
      dataHold <= '0;
      pendData <= '0;
    end else begin
      if (ctl.clearCnt)     loadCnt <= '0;
      else if (ctl.advance) loadCnt <= loadCnt + 1'b1;
      if (ctl.savePend) pendData <= dataIn;
      if (ctl.capNew) begin
        dataHold <= dataIn;
        addrHold <= loadCnt;
      end else if (ctl.capPend) begin
        dataHold <= pendData;
        addrHold <= loadCnt;
      end
    end
  end

  assign ramAddr = addrHold;
  assign ramData = dataHold;
endmodule

// File: rtl/pport_loader.sv
module pport_loader
  import pport_loader_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int SYNC_STAGES    = 2,
  parameter int PULSE_CYCLES   = 8,
  parameter int TIMEOUT_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobeN,
  input  logic [7:0]        dataIn,
  output logic              busy,
  output logic              ack,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramData,
  output logic              loadMode,
  output logic              targetResetN,
  output logic              activity
);
  logic fallSeen, riseSeen, writeActive, sessionActive;
  ctlStrobes_t ctl;

  pport_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .strobeN(strobeN),
    .fallSeen(fallSeen), .riseSeen(riseSeen)
  );

  pport_load_ctrl #(.PULSE_CYCLES(PULSE_CYCLES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .fallSeen(fallSeen), .riseSeen(riseSeen),
    .ctl(ctl), .busy(busy), .writeActive(writeActive), .sessionActive(sessionActive)
  );

  pport_load_dp #(.ADDR_W(ADDR_W), .DATA_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataIn(dataIn),
    .ramAddr(ramAddr), .ramData(ramData)
  );

  assign ack          = writeActive;
  assign ramWe        = writeActive;
  assign loadMode     = sessionActive;
  assign targetResetN = ~sessionActive;
  assign activity     = sessionActive;
endmodule

// File: rtl/pport_loader_checker.sv
module pport_loader_checker #(
  parameter int ADDR_W       = 16,
  parameter int PULSE_CYCLES = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              ack,
  input logic              ramWe,
  input logic [ADDR_W-1:0] ramAddr,
  input logic [7:0]        ramData,
  input logic              loadMode,
  input logic              targetResetN
);
  int weRun;
  always_ff @(posedge clk) begin
    if (!rstN)      weRun <= 0;
    else if (ramWe) weRun <= weRun + 1;
    else            weRun <= 0;
  end

  p_we_needs_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe || ack) |-> (busy && loadMode));

  p_pulse_length_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ramWe && weRun != 0) |-> (weRun == PULSE_CYCLES));

  p_write_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && weRun != 0) |-> ($stable(ramAddr) && $stable(ramData)));

  p_busy_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ramWe && weRun != 0) |-> !busy);

  p_reset_tracks_r6: assert property (@(posedge clk) disable iff (!rstN)
    targetResetN == !loadMode);

  p_quiet_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(loadMode) |-> (!busy && !ramWe));
endmodule

bind pport_loader pport_loader_checker #(.ADDR_W(ADDR_W), .PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .ack(ack), .ramWe(ramWe),
  .ramAddr(ramAddr), .ramData(ramData), .loadMode(loadMode),
  .targetResetN(targetResetN)
);

// File: tb/pport_loader_bench.sv
module pport_loader_bench;
  localparam int AW    = 16;
  localparam int PULSE = 6;
  localparam int TOUT  = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strobeN = 1'b1;
  logic [7:0] dataIn = '0;
  logic busy, ack, ramWe, loadMode, targetResetN, activity;
  logic [AW-1:0] ramAddr;
  logic [7:0] ramData;

  int nChecks = 0;
  int nFails = 0;
  int r6Bad = 0;
  bit finished = 0;
  logic [AW-1:0] expAddr = '0;
  logic [AW+7:0] sbQ[$];
  int writesSeen = 0;

  always #4 clk = ~clk;

  pport_loader #(.ADDR_W(AW), .SYNC_STAGES(2), .PULSE_CYCLES(PULSE), .TIMEOUT_CYCLES(TOUT)) u_pport_loader (
    .clk(clk), .rstN(rstN), .strobeN(strobeN), .dataIn(dataIn),
    .busy(busy), .ack(ack), .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData),
    .loadMode(loadMode), .targetResetN(targetResetN), .activity(activity)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] d, input int lowC, input int highC);
    @(negedge clk);
    dataIn  = d;
    strobeN = 1'b0;
    sbQ.push_back({expAddr, d});
    expAddr++;
    repeat (lowC) @(negedge clk);
    strobeN = 1'b1;
    repeat (highC) @(negedge clk);
  endtask

  // monitor: scoreboard pop on write start, pulse length on write end
  logic prevWe = 1'b0;
  int   runLen = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (loadMode && (targetResetN !== 1'b0 || activity !== 1'b1)) r6Bad++;
      if (!loadMode && (targetResetN !== 1'b1 || activity !== 1'b0)) r6Bad++;
      if (ramWe && !prevWe) begin
        writesSeen++;
        if (sbQ.size() == 0) begin
          check("R7 unexpected write", 32'(ramAddr), 32'hFFFFFFFF);
        end else begin
          logic [AW+7:0] item;
          item = sbQ.pop_front();
          check("R4 write address", 32'(ramAddr), 32'(item[AW+7:8]));
          check("R3 write data", 32'(ramData), 32'(item[7:0]));
        end
        check("R3 ack with write", 32'(ack), 32'd1);
      end
      if (ramWe) runLen++;
      if (!ramWe && prevWe) begin
        check("R3 pulse length", 32'(runLen), 32'(PULSE));
        runLen = 0;
      end
      prevWe = ramWe;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: state after reset
    check("R1 loadMode", 32'(loadMode), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 ramWe/ack", 32'({ramWe, ack}), 0);
    check("R1 targetResetN", 32'(targetResetN), 1);
    check("R1 activity", 32'(activity), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2: first falling edge opens the session
    dataIn  = 8'h3C;
    strobeN = 1'b0;
    sbQ.push_back({expAddr, 8'h3C});
    expAddr++;
    repeat (4) @(negedge clk);
    check("R2 loadMode", 32'(loadMode), 1);
    check("R2 busy", 32'(busy), 1);
    check("R2 targetResetN", 32'(targetResetN), 0);
    check("R2 activity", 32'(activity), 1);
    check("R3 no write before rise", 32'(ramWe), 0);
    repeat (2) @(negedge clk);
    strobeN = 1'b1;
    repeat (PULSE + 6) @(negedge clk);
    check("R4 busy released", 32'(busy), 0);

    // R8: gaps shorter than the timeout keep the session open
    sendByte(8'hC3, 6, 45);
    check("R8 session held", 32'(loadMode), 1);
    sendByte(8'h00, 5, 45);
    check("R8 session held", 32'(loadMode), 1);
    sendByte(8'hFF, 7, 45);
    check("R8 session held", 32'(loadMode), 1);

    // R7: next byte arrives entirely within the previous write pulse
    sendByte(8'h11, 4, 2);
    sendByte(8'h22, 2, 20);
    check("R7 pending writes done", 32'(sbQ.size()), 0);
    check("R7 busy after pending", 32'(busy), 0);

    // R5: silence ends the session
    repeat (TOUT + 10) @(negedge clk);
    check("R5 loadMode", 32'(loadMode), 0);
    check("R5 targetResetN", 32'(targetResetN), 1);
    check("R5 activity", 32'(activity), 0);

    // R5/R4: new session restarts at address 0
    expAddr = '0;
    sendByte(8'h77, 6, 20);
    sendByte(8'h88, 6, 20);
    repeat (TOUT + 10) @(negedge clk);
    check("R4 all writes seen", 32'(writesSeen), 8);
    check("R4 queue empty", 32'(sbQ.size()), 0);
    check("R5 second exit", 32'(loadMode), 0);
    check("R6 reset/activity track loadMode", 32'(r6Bad), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule